// File: doc/BRIEF.md
# Pointer-Addressed I2C Target Front End

This block is the bus side of a small I2C target. It runs from a system clock much faster than the bus clock. It filters and samples SCL and SDA, detects START, repeated START and STOP, and recognises a 7-bit target address. The upper five bits of that address are a parameter (default `11100`). The two low bits come from strap inputs, so four copies can share one bus. The block pulls SDA low through an open-drain enable. It never holds SCL low, so it does not stretch the clock.

The first byte after a write address is a command byte. Its low bits load a register pointer, and that pointer does not advance by itself. Every later data byte written in the same transfer goes to the pointed register. Reads go to the same register too: after a repeated START in that transfer, and in later transfers that send only a read address. This continues until a new command byte arrives.

Register traffic uses single-cycle strobes, and there is no back-pressure in either direction. On a write strobe the register bank must take `reg_wdata` at `reg_idx` in that same cycle. On a read strobe it must present `reg_rdata` for `reg_idx` combinationally in that same cycle. The bank can use the read strobe to clear read-sensitive state, such as a change flag.

Top module: `i2c_ptr_slave`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `11100` followed by `strap_addr[1]`, `strap_addr[0]`. The eighth bit is the direction bit, and 1 means read. On a mismatch the target leaves SDA released and issues no strobe until the next START.
- R2: The first byte after a matching write address is acknowledged, and its two low bits become the register pointer shown on `reg_idx`. Its upper bits are ignored.
- R3: Each further written byte is acknowledged and produces exactly one single-cycle `reg_wr_en` pulse, with `reg_wdata` equal to the byte (received MSB first) and `reg_idx` equal to the pointer.
- R4: The pointer never advances. Several data bytes in one write transfer all land on the same register index.
- R5: After a repeated START with a matching read address, the target pulses `reg_rd_en` while SCL is low and shifts out `reg_rdata` on SDA, MSB first.
- R6: A transfer that begins directly with a matching read address reads the register selected by the last command byte, including one from an earlier transfer.
- R7: A master acknowledge after a read byte causes another read strobe and another byte from the same register. A master NACK leaves SDA released, with no further read strobe.
- R8: A STOP at any point returns the target to idle and releases SDA. A partly received data byte produces no write strobe. A command byte already acknowledged keeps its pointer.
- R9: A pulse on SCL or SDA shorter than `FILT_CYCLES` system clocks (12 by default, 60 ns at 200 MHz) has no effect on the received data.
- R10: While `rst_n` is low, and after it, SDA is released, the pointer is 0 and no strobes are issued. This applies even if the reset arrives in the middle of a transfer.
- R11: The target starts pulling SDA low only while SCL is low. It releases SDA only while SCL is low, or right after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_addr | input | 2 | Low two bits of the target address |
| reg_idx | output | 2 | Current register pointer |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data, valid with `reg_wr_en` |
| reg_rd_en | output | 1 | One-cycle read strobe; `reg_rdata` captured in this cycle |
| reg_rdata | input | 8 | Read data for `reg_idx` from the register bank |

## Verification
A corrupted pointer appears on `reg_idx` at once. It also reaches the register bank as a wrong write index or wrong read data on the very next data byte, which is at most nine SCL periods later. A bit counter that is off by one moves the acknowledge into a data slot. The master then sees a missing or misplaced ACK within the same byte, and the strobe carries shifted data. A filter that lets a short spike through adds an extra bit, and that shows up as a wrong `reg_wdata` value on the strobe that ends the affected byte. A state that fails to return to idle on STOP or on a NACK shows up as SDA being pulled low outside its slots, or as strobes after the bus has gone idle.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_MACK
  } i2cs_state_e;
endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYCLES = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = (FILT_CYCLES > 1) ? $clog2(FILT_CYCLES) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   level;

  assign level = sync_q[SYNC_STAGES-1];

  // The output follows the synchronised input only after FILT_CYCLES
  // consecutive samples that disagree with it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      cnt_q  <= '0;
      dout   <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (level == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(FILT_CYCLES - 1)) begin
        dout  <= level;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W  = 7,
  parameter int STRAP_W = 2,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_ADDR = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_in,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic              sda_oe,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int BW = $clog2(DATA_W);
  localparam logic [BW-1:0] LAST = BW'(DATA_W - 1);

  i2cs_state_e       state_q, after_ack_q;
  logic [BW-1:0]     bitcnt_q;
  logic [DATA_W-1:0] rx_q, tx_q, rx_byte;
  logic [IDX_W-1:0]  ptr_q;
  logic              ack_pend_q;
  logic [ADDR_W-1:0] own_addr;
  logic              load_now;

  assign own_addr = {FIXED_ADDR, strap_addr};
  assign rx_byte  = {rx_q[DATA_W-2:0], sda_in};
  assign reg_idx  = ptr_q;

  // A byte is fetched for transmission on the SCL fall that ends the
  // slave's address ACK or a master ACK.
  assign load_now = scl_fall && !ack_pend_q &&
                    ((state_q == ST_ACK && after_ack_q == ST_TX) ||
                     state_q == ST_MACK);
  assign reg_rd_en = load_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      after_ack_q <= ST_IDLE;
      bitcnt_q    <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      ack_pend_q  <= 1'b0;
      sda_oe      <= 1'b0;
      reg_wr_en   <= 1'b0;
      reg_wdata   <= '0;
    end else begin
      reg_wr_en <= 1'b0;
      if (start_det) begin
        state_q    <= ST_ADDR;
        bitcnt_q   <= '0;
        ack_pend_q <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (stop_det) begin
        state_q    <= ST_IDLE;
        ack_pend_q <= 1'b0;
        sda_oe     <= 1'b0;
      end else if (scl_rise) begin
        case (state_q)
          ST_ADDR, ST_CMD, ST_WDAT: begin
            rx_q     <= rx_byte;
            bitcnt_q <= bitcnt_q + 1'b1;
            if (bitcnt_q == LAST) begin
              case (state_q)
                ST_ADDR: begin
                  if (rx_byte[DATA_W-1 -: ADDR_W] == own_addr) begin
                    ack_pend_q  <= 1'b1;
                    after_ack_q <= rx_byte[0] ? ST_TX : ST_CMD;
                  end else begin
                    state_q <= ST_IDLE;
                  end
                end
                ST_CMD: begin
                  ptr_q       <= rx_byte[IDX_W-1:0];
                  ack_pend_q  <= 1'b1;
                  after_ack_q <= ST_WDAT;
                end
                default: begin
                  reg_wr_en   <= 1'b1;
                  reg_wdata   <= rx_byte;
                  ack_pend_q  <= 1'b1;
                  after_ack_q <= ST_WDAT;
                end
              endcase
            end
          end
          ST_MACK: if (sda_in) state_q <= ST_IDLE;
          default: ;
        endcase
      end else if (scl_fall) begin
        if (ack_pend_q) begin
          ack_pend_q <= 1'b0;
          sda_oe     <= 1'b1;
          state_q    <= ST_ACK;
        end else if (load_now) begin
          tx_q     <= reg_rdata;
          sda_oe   <= ~reg_rdata[DATA_W-1];
          bitcnt_q <= '0;
          state_q  <= ST_TX;
        end else begin
          case (state_q)
            ST_ACK: begin
              sda_oe   <= 1'b0;
              bitcnt_q <= '0;
              state_q  <= after_ack_q;
            end
            ST_TX: begin
              if (bitcnt_q == LAST) begin
                sda_oe  <= 1'b0;
                state_q <= ST_MACK;
              end else begin
                sda_oe   <= ~tx_q[DATA_W-2];
                tx_q     <= {tx_q[DATA_W-2:0], 1'b0};
                bitcnt_q <= bitcnt_q + 1'b1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/i2c_ptr_slave.sv
module i2c_ptr_slave #(
  parameter int ADDR_W      = 7,
  parameter int STRAP_W     = 2,
  parameter int DATA_W      = 8,
  parameter int IDX_W       = 2,
  parameter int FILT_CYCLES = 12,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-STRAP_W-1:0] FIXED_ADDR = 5'b11100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [STRAP_W-1:0] strap_addr,
  output logic [IDX_W-1:0]  reg_idx,
  output logic              reg_wr_en,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_rd_en,
  input  logic [DATA_W-1:0] reg_rdata
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw_lines, filt_lines;
  logic scl_f, sda_f;
  logic scl_rise, scl_fall, start_det, stop_det;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2cs_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYCLES(FILT_CYCLES)
    ) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (raw_lines[g]),
      .dout (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  i2cs_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl      (scl_f),
    .sda      (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_engine #(
    .ADDR_W    (ADDR_W),
    .STRAP_W   (STRAP_W),
    .DATA_W    (DATA_W),
    .IDX_W     (IDX_W),
    .FIXED_ADDR(FIXED_ADDR)
  ) u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_in    (sda_f),
    .strap_addr(strap_addr),
    .sda_oe    (sda_oe),
    .reg_idx   (reg_idx),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );
endmodule

// File: rtl/i2c_ptr_slave_checker.sv
module i2c_ptr_slave_checker #(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_f,
  input logic             start_det,
  input logic             stop_det,
  input logic             sda_oe,
  input logic             reg_wr_en,
  input logic             reg_rd_en,
  input logic [IDX_W-1:0] reg_idx
);
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |=> !reg_wr_en); // R3

  AST_NO_RD_WITH_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_en && reg_rd_en)); // R5

  AST_RD_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_en |-> !scl_f); // R5

  AST_IDX_HELD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en |-> $stable(reg_idx)); // R4

  AST_STOP_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe); // R8

  AST_PULL_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f); // R11

  AST_RELEASE_SCL_LOW_OR_COND: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> (!scl_f || $past(stop_det) || $past(start_det))); // R11
endmodule

bind i2c_ptr_slave i2c_ptr_slave_checker #(.IDX_W(IDX_W)) u_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_f    (scl_f),
  .start_det(start_det),
  .stop_det (stop_det),
  .sda_oe   (sda_oe),
  .reg_wr_en(reg_wr_en),
  .reg_rd_en(reg_rd_en),
  .reg_idx  (reg_idx)
);

// File: tb/i2c_ptr_slave_bench.sv
module i2c_ptr_slave_bench;
  localparam int Q = 30;  // quarter SCL period in system clocks

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_wr_en, reg_rd_en;
  logic [1:0] reg_idx;
  logic [7:0] reg_wdata, reg_rdata;
  logic [1:0] strap = 2'b10;
  logic sda_line;
  logic [7:0] bank [4];

  int checks = 0, fails = 0;
  int wr_cnt = 0, rd_cnt = 0, oe_rises = 0, bad_edge = 0;
  logic [1:0] last_idx;
  logic [7:0] last_wd;
  logic oe_q = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign sda_line  = sda_m & ~sda_oe;
  assign reg_rdata = bank[reg_idx];

  i2c_ptr_slave u_i2c_ptr_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_line),
    .sda_oe    (sda_oe),
    .strap_addr(strap),
    .reg_idx   (reg_idx),
    .reg_wr_en (reg_wr_en),
    .reg_wdata (reg_wdata),
    .reg_rd_en (reg_rd_en),
    .reg_rdata (reg_rdata)
  );

  initial for (int k = 0; k < 4; k++) bank[k] = 8'h00;

  always @(posedge clk) begin
    if (reg_wr_en) begin
      wr_cnt   <= wr_cnt + 1;
      last_idx <= reg_idx;
      last_wd  <= reg_wdata;
      bank[reg_idx] <= reg_wdata;
    end
    if (reg_rd_en) rd_cnt <= rd_cnt + 1;
    oe_q <= sda_oe;
    if (sda_oe && !oe_q) begin
      oe_rises <= oe_rises + 1;
      if (scl_m) bad_edge <= bad_edge + 1;  // R11 monitor
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); sda_m = 1'b0; q(); scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q(); scl_m = 1'b1; q(); sda_m = 1'b1; q();
  endtask

  task automatic put_bit(input logic v, input bit glitch);
    sda_m = v;
    if (glitch) begin
      repeat (8) @(negedge clk); scl_m = 1'b1;
      repeat (5) @(negedge clk); scl_m = 1'b0;
      repeat (Q - 13) @(negedge clk);
    end else q();
    scl_m = 1'b1; q(); q(); scl_m = 1'b0; q();
  endtask

  task automatic send_byte(input logic [7:0] b, input int glitch_bit, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i], i == glitch_bit);
    sda_m = 1'b1; q(); scl_m = 1'b1; q(); ack = !sda_line; q(); scl_m = 1'b0; q();
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; q(); scl_m = 1'b1; q(); b[i] = sda_line; q(); scl_m = 1'b0; q();
    end
    sda_m = !mack; q(); scl_m = 1'b1; q(); q(); scl_m = 1'b0; q(); sda_m = 1'b1;
  endtask

  task automatic read_only(output logic [7:0] b);
    logic a;
    bus_start(); send_byte({7'h72, 1'b1}, -1, a); recv_byte(1'b0, b); bus_stop();
  endtask

  typedef struct packed {
    logic [6:0] addr;
    logic [7:0] cmd;
    logic [7:0] data;
    logic       ack;
    logic [1:0] idx;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{7'h72, 8'h01, 8'hA5, 1'b1, 2'd1},
    '{7'h72, 8'h02, 8'h3C, 1'b1, 2'd2},
    '{7'h72, 8'hFF, 8'h81, 1'b1, 2'd3},
    '{7'h70, 8'h01, 8'h99, 1'b0, 2'd0},
    '{7'h73, 8'h02, 8'h66, 1'b0, 2'd0},
    '{7'h72, 8'h04, 8'h5A, 1'b1, 2'd0}
  };

  initial begin
    logic a;
    logic [7:0] b, b2;
    int w0, r0;
    repeat (10) @(negedge clk);
    // R10: reset state
    chk("R10 sda_oe in reset", sda_oe, 0);
    chk("R10 pointer in reset", reg_idx, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    chk("R10 no strobes after reset", wr_cnt + rd_cnt, 0);

    // Vector table: address match, command, single write, sticky read-back
    for (int i = 0; i < 6; i++) begin
      w0 = wr_cnt; r0 = oe_rises;
      bus_start();
      send_byte({VECS[i].addr, 1'b0}, -1, a);
      chk("R1 address ack", a, VECS[i].ack);
      if (VECS[i].ack) begin
        send_byte(VECS[i].cmd, -1, a);  chk("R2 command ack", a, 1);
        send_byte(VECS[i].data, -1, a); chk("R3 data ack", a, 1);
        bus_stop();
        chk("R3 one write strobe", wr_cnt - w0, 1);
        chk("R2 pointer from low bits", last_idx, VECS[i].idx);
        chk("R3 write data", last_wd, VECS[i].data);
        read_only(b);
        chk("R6 read-only reuses pointer", b, VECS[i].data);
      end else begin
        send_byte(VECS[i].cmd, -1, a);
        bus_stop();
        chk("R1 mismatch no strobe", wr_cnt - w0, 0);
        chk("R1 mismatch SDA untouched", oe_rises - r0, 0);
      end
    end

    // R4: several data bytes, same register
    w0 = wr_cnt;
    bus_start(); send_byte(8'hE4, -1, a); send_byte(8'h01, -1, a);
    send_byte(8'h11, -1, a); send_byte(8'h22, -1, a); send_byte(8'h33, -1, a);
    bus_stop();
    chk("R4 three strobes", wr_cnt - w0, 3);
    chk("R4 index unchanged", last_idx, 1);
    read_only(b);
    chk("R4 last byte kept", b, 8'h33);

    // R5/R7: combined write-pointer + repeated START read, two bytes
    r0 = rd_cnt;
    bus_start(); send_byte(8'hE4, -1, a); send_byte(8'h02, -1, a);
    bus_rstart(); send_byte(8'hE5, -1, a);
    chk("R5 read address ack", a, 1);
    recv_byte(1'b1, b);
    recv_byte(1'b0, b2);
    chk("R7 SDA released after NACK", sda_oe, 0);
    bus_stop();
    chk("R5 first byte MSB first", b, 8'h3C);
    chk("R7 second byte same register", b2, 8'h3C);
    chk("R7 two read strobes", rd_cnt - r0, 2);

    // R8: STOP inside a data byte
    w0 = wr_cnt;
    bus_start(); send_byte(8'hE4, -1, a); send_byte(8'h03, -1, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop();
    chk("R8 no strobe for partial byte", wr_cnt - w0, 0);
    chk("R8 SDA released", sda_oe, 0);
    chk("R8 pointer kept", reg_idx, 3);
    read_only(b);
    chk("R8 register untouched", b, 8'h81);

    // R9: short SCL spikes inside command and data bytes
    w0 = wr_cnt;
    bus_start(); send_byte(8'hE4, -1, a); send_byte(8'h01, 2, a);
    send_byte(8'hC3, 5, a);
    chk("R9 ack after glitched byte", a, 1);
    bus_stop();
    chk("R9 one strobe", wr_cnt - w0, 1);
    chk("R9 index intact", last_idx, 1);
    chk("R9 data intact", last_wd, 8'hC3);

    // R10: reset in the middle of a transfer
    bus_start(); send_byte(8'hE4, -1, a); send_byte(8'h02, -1, a);
    chk("R10 pointer before reset", reg_idx, 2);
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 SDA released in reset", sda_oe, 0);
    chk("R10 pointer cleared", reg_idx, 0);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    read_only(b);
    chk("R10 read after reset uses register 0", b, 8'h5A);

    chk("R11 SDA pulled only with SCL low", bad_edge, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule